// File: doc/BRIEF.md
# Power-Up Register Boot Loader

After reset, this sequencer copies configuration and coefficient bytes from an external byte-wide ROM into the register banks of a chain of up to sixteen cascaded devices. It works on its own slow clock, so the load does not depend on the main processing clock. Each device owns one 128-byte ROM page. The loader reads the nine control bytes at the start of the page and the 64 coefficient bytes at its top. It skips the 55 bytes in between. Each byte it reads goes out as a write on the expansion bus to the register it belongs to.

The write strobe has no fixed width. It stays up until a feedback signal, sent back from the far end of the chain, shows that every device has seen it. The strobe then drops, and the loader waits for the feedback to clear before it fetches the next byte. With one device on its own, the loop is closed inside the block and the external feedback pin is not used. The program-enable output marks the whole load, and a done flag marks the end of it.

Top module: `boot_loader`

## Requirements
- R1: While `rst` is high, `prog_o`, `strobe_o` and `done_o` are low, `rom_addr_o` is 0, and `rw_o` is low.
- R2: On the first clock edge after `rst` is released, `prog_o` goes high. It stays high until the load ends, and it drops only in the same cycle that `done_o` rises.
- R3: Within each page, writes use the page offsets 0 to 8 in ascending order, then 64 to 127 in ascending order. While the strobe is high, an offset from 9 to 63 is never on the ROM address.
- R4: During a write, `rom_addr_o` equals the device index times 128 plus the page offset. The index is in bits 10:7 and the offset is in bits 6:0.
- R5: The register address on `bus_addr_o` is equal to the offset for offsets 0 to 8, and to the offset minus 55 for offsets 64 to 127. This gives register numbers 0 to 72. `bus_data_o` carries the ROM byte read at that address.
- R6: Pages are loaded for devices 0 through `dev_last_i`, in order, and `bus_dev_o` names the device being written. Each load makes exactly 73 × (`dev_last_i`+1) writes.
- R7: When `single_i` is low, a strobe that has risen stays high until `fb_i` has been seen high. The next strobe rises only after `fb_i` has been seen low.
- R8: When `single_i` is high, `fb_i` has no effect, and every strobe is high for exactly 2 cycles.
- R9: `rw_o` is always low, which marks every access as a write.
- R10: After the last write of the last device is released, `done_o` goes high and `prog_o` goes low. Both hold at those values until reset, and no further strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader oscillator clock |
| rst | input | 1 | Synchronous active-high reset; loading starts when it is released |
| single_i | input | 1 | 1 = lone device, strobe loop closed internally |
| dev_last_i | input | 4 | Number of devices minus one |
| fb_i | input | 1 | Strobe returning from the end of the chain |
| rom_data_i | input | 8 | Byte read from the ROM |
| rom_addr_o | output | 11 | ROM address {device, offset} |
| prog_o | output | 1 | Program enable, high for the whole load |
| strobe_o | output | 1 | Write data strobe to the chain |
| rw_o | output | 1 | Read/write line, held low (write) |
| bus_dev_o | output | 4 | Index of the device being written |
| bus_addr_o | output | 7 | Register address on the expansion bus |
| bus_data_o | output | 8 | Register data on the expansion bus |
| done_o | output | 1 | Load complete |

## Verification
The assertions assume three things about the inputs. `dev_last_i` and `single_i` stay fixed for the whole load. The ROM returns a byte within the programmed wait. `fb_i` follows the strobe with a delay and does not toggle on its own. The bench changes the configuration inputs only while reset is held. It produces `fb_i` as a delayed copy of `strobe_o`, using a delay it sets for each scenario, and it models the ROM as a combinational function of the address. In internal-loop mode it holds `fb_i` at 0, so it can show that the pin is ignored.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH,
    ST_STRB,
    ST_REL,
    ST_DONE
  } boot_st_t;
endpackage

// File: rtl/boot_addr_ctr.sv
// Device and page-offset counters; steps over the unused middle of a page.
module boot_addr_ctr #(
  parameter int DEV_W  = 4,
  parameter int OFF_W  = 7,
  parameter int CTRL_N = 9,
  parameter int COEF_N = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [DEV_W-1:0] dev_last,
  output logic [DEV_W-1:0] dev,
  output logic [OFF_W-1:0] off,
  output logic             at_end
);
  localparam int PAGE    = 1 << OFF_W;
  localparam int SKIP_TO = PAGE - COEF_N;

  logic page_end;
  assign page_end = (off == OFF_W'(PAGE - 1));
  assign at_end   = page_end && (dev == dev_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      dev <= '0;
      off <= '0;
    end else if (step && !at_end) begin
      if (off == OFF_W'(CTRL_N - 1)) begin
        off <= OFF_W'(SKIP_TO);
      end else if (page_end) begin
        off <= '0;
        dev <= dev + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_fb_sel.sv
// Chooses the strobe feedback: internal loop for a lone device, else chain return.
module boot_fb_sel (
  input  logic clk,
  input  logic rst,
  input  logic single,
  input  logic strobe,
  input  logic fb_ext,
  output logic fb
);
  logic loop_q;

  always_ff @(posedge clk) begin
    if (rst) loop_q <= 1'b0;
    else     loop_q <= strobe;
  end

  assign fb = single ? loop_q : fb_ext;
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int DEV_W    = 4,
  parameter int OFF_W    = 7,
  parameter int CTRL_N   = 9,
  parameter int COEF_N   = 64,
  parameter int DATA_W   = 8,
  parameter int ROM_WAIT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   single_i,
  input  logic [DEV_W-1:0]       dev_last_i,
  input  logic                   fb_i,
  input  logic [DATA_W-1:0]      rom_data_i,
  output logic [DEV_W+OFF_W-1:0] rom_addr_o,
  output logic                   prog_o,
  output logic                   strobe_o,
  output logic                   rw_o,
  output logic [DEV_W-1:0]       bus_dev_o,
  output logic [$clog2(CTRL_N+COEF_N)-1:0] bus_addr_o,
  output logic [DATA_W-1:0]      bus_data_o,
  output logic                   done_o
);
  import boot_pkg::*;

  localparam int PAGE   = 1 << OFF_W;
  localparam int GAP    = PAGE - COEF_N - CTRL_N;
  localparam int REG_W  = $clog2(CTRL_N + COEF_N);
  localparam int WAIT_W = $clog2(ROM_WAIT + 1);

  boot_st_t          st;
  logic [WAIT_W-1:0] wcnt;
  logic [DEV_W-1:0]  dev;
  logic [OFF_W-1:0]  off;
  logic              at_end;
  logic              fb;
  logic              step;
  logic [REG_W-1:0]  reg_idx;

  assign step = (st == ST_REL) && !fb;

  boot_addr_ctr #(
    .DEV_W(DEV_W), .OFF_W(OFF_W), .CTRL_N(CTRL_N), .COEF_N(COEF_N)
  ) u_ctr (
    .clk(clk), .rst(rst), .step(step), .dev_last(dev_last_i),
    .dev(dev), .off(off), .at_end(at_end)
  );

  boot_fb_sel u_fb (
    .clk(clk), .rst(rst), .single(single_i), .strobe(strobe_o),
    .fb_ext(fb_i), .fb(fb)
  );

  always_comb begin
    if (off < OFF_W'(CTRL_N)) reg_idx = REG_W'(off);
    else                      reg_idx = REG_W'(off - OFF_W'(GAP));
  end

  assign rom_addr_o = {dev, off};
  assign bus_dev_o  = dev;
  assign rw_o       = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_BOOT;
      wcnt       <= '0;
      prog_o     <= 1'b0;
      strobe_o   <= 1'b0;
      done_o     <= 1'b0;
      bus_addr_o <= '0;
      bus_data_o <= '0;
    end else begin
      case (st)
        ST_BOOT: begin
          prog_o <= 1'b1;
          wcnt   <= '0;
          st     <= ST_FETCH;
        end
        ST_FETCH: begin
          if (wcnt == WAIT_W'(ROM_WAIT - 1)) begin
            bus_data_o <= rom_data_i;
            bus_addr_o <= reg_idx;
            strobe_o   <= 1'b1;
            wcnt       <= '0;
            st         <= ST_STRB;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_STRB: begin
          if (fb) begin
            strobe_o <= 1'b0;
            st       <= ST_REL;
          end
        end
        ST_REL: begin
          if (!fb) begin
            if (at_end) begin
              prog_o <= 1'b0;
              done_o <= 1'b1;
              st     <= ST_DONE;
            end else begin
              st <= ST_FETCH;
            end
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        single_i,
  input logic        fb_i,
  input logic [10:0] rom_addr_o,
  input logic        prog_o,
  input logic        strobe_o,
  input logic [3:0]  bus_dev_o,
  input logic [6:0]  bus_addr_o,
  input logic        done_o
);
  a_r2_prog_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_o) |-> done_o);

  a_r3_no_middle: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (rom_addr_o[6:0] < 7'd9 || rom_addr_o[6:0] > 7'd63));

  a_r5_reg_map: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (bus_addr_o == ((rom_addr_o[6:0] < 7'd9) ? rom_addr_o[6:0]
                                                           : rom_addr_o[6:0] - 7'd55)));

  a_r6_dev_match: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (bus_dev_o == rom_addr_o[10:7]));

  a_r7_hold_until_fb: assert property (@(posedge clk) disable iff (rst)
    (!single_i && $fell(strobe_o)) |-> $past(fb_i));

  a_r8_two_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
    (single_i && $rose(strobe_o)) |=> strobe_o ##1 !strobe_o);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!strobe_o && !prog_o));
endmodule

bind boot_loader boot_loader_chk u_chk (
  .clk(clk), .rst(rst), .single_i(single_i), .fb_i(fb_i),
  .rom_addr_o(rom_addr_o), .prog_o(prog_o), .strobe_o(strobe_o),
  .bus_dev_o(bus_dev_o), .bus_addr_o(bus_addr_o), .done_o(done_o)
);

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        single_i = 1'b0;
  logic [3:0]  dev_last_i = '0;
  logic        fb_i;
  logic [7:0]  rom_data_i;
  logic [10:0] rom_addr_o;
  logic        prog_o, strobe_o, rw_o, done_o;
  logic [3:0]  bus_dev_o;
  logic [6:0]  bus_addr_o;
  logic [7:0]  bus_data_o;

  int n_run = 0;
  int n_fail = 0;
  int fb_dly = 1;
  logic fb_en = 1'b1;
  logic [7:0] sr = '0;

  always #5 clk = ~clk;

  always @(posedge clk) sr <= {sr[6:0], strobe_o};
  assign fb_i = fb_en ? sr[fb_dly-1] : 1'b0;

  function automatic logic [7:0] romf(input logic [10:0] a);
    logic [10:0] t;
    t = a * 11'd29 + 11'd7;
    return t[7:0] ^ {4'h0, a[10:7]};
  endfunction
  assign rom_data_i = romf(rom_addr_o);

  boot_loader u_dut (
    .clk(clk), .rst(rst), .single_i(single_i), .dev_last_i(dev_last_i),
    .fb_i(fb_i), .rom_data_i(rom_data_i), .rom_addr_o(rom_addr_o),
    .prog_o(prog_o), .strobe_o(strobe_o), .rw_o(rw_o), .bus_dev_o(bus_dev_o),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic sgl, input logic [3:0] last, input int dly, input logic fen);
    @(negedge clk);
    rst = 1'b1; single_i = sgl; dev_last_i = last; fb_dly = dly; fb_en = fen;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!prog_o && !strobe_o && !done_o, "R1 ctrl low", {prog_o, strobe_o, done_o}, 0);
    chk(rom_addr_o == 0, "R1 rom_addr", rom_addr_o, 0);
    chk(rw_o == 0, "R1 rw", rw_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(prog_o == 1'b1, "R2 prog after release", prog_o, 1);
  endtask

  // Runs one full load and checks each write as it appears.
  task automatic run_load(input logic sgl, input logic [3:0] last, input int dly, input logic fen);
    int k = 0, cyc = 0, hi = 0, bad_w = 0, bad_r = 0, bad_p = 0, bad_h = 0, bad_s = 0, bad_q = 0;
    logic prev_s = 1'b0, prev_fb = 1'b0;
    int total;
    total = 73 * (int'(last) + 1);
    do_reset(sgl, last, dly, fen);
    while (!done_o && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (strobe_o && !prev_s) begin
        int d, r, o, ea;
        d = k / 73; r = k % 73; o = (r < 9) ? r : r + 55; ea = d * 128 + o;
        if (rom_addr_o != 11'(ea)) begin bad_w++;
          chk(0, "R3/R4 rom_addr", rom_addr_o, ea); end
        if (bus_addr_o != 7'(r)) begin bad_w++;
          chk(0, "R5 bus_addr", bus_addr_o, r); end
        if (bus_data_o != romf(11'(ea))) begin bad_w++;
          chk(0, "R5 bus_data", bus_data_o, romf(11'(ea))); end
        if (bus_dev_o != 4'(d)) begin bad_w++;
          chk(0, "R6 bus_dev", bus_dev_o, d); end
        if (!sgl && prev_fb) begin bad_h++;
          chk(0, "R7 rise before fb low", prev_fb, 0); end
        k++; hi = 0;
      end
      if (strobe_o) hi++;
      if (!strobe_o && prev_s) begin
        if (!sgl && !prev_fb) begin bad_h++;
          chk(0, "R7 fell before fb", prev_fb, 1); end
        if (sgl && hi != 2) begin bad_s++;
          chk(0, "R8 strobe width", hi, 2); end
      end
      if (!prog_o && !done_o) bad_p++;
      if (rw_o) bad_r++;
      prev_s = strobe_o; prev_fb = fb_i;
    end
    chk(bad_w == 0, "R3/R4/R5/R6 write fields", bad_w, 0);
    chk(bad_p == 0, "R2 prog held", bad_p, 0);
    chk(bad_r == 0, "R9 rw low", bad_r, 0);
    if (!sgl) chk(bad_h == 0, "R7 handshake", bad_h, 0);
    else      chk(bad_s == 0, "R8 internal loop", bad_s, 0);
    chk(done_o == 1'b1, "R10 done reached", done_o, 1);
    chk(k == total, "R6 write count", k, total);
    repeat (30) begin
      @(negedge clk);
      if (strobe_o || prog_o || !done_o) bad_q++;
    end
    chk(bad_q == 0, "R10 quiet after done", bad_q, 0);
  endtask

  task automatic t_one_device_chain();  run_load(1'b0, 4'd0, 3, 1'b1); endtask
  task automatic t_three_devices();     run_load(1'b0, 4'd2, 5, 1'b1); endtask
  task automatic t_sixteen_devices();   run_load(1'b0, 4'd15, 1, 1'b1); endtask
  task automatic t_internal_loop();     run_load(1'b1, 4'd1, 1, 1'b0); endtask
  task automatic t_internal_fb_high();  run_load(1'b1, 4'd0, 1, 1'b1); endtask

  initial begin
    fork
      begin
        t_one_device_chain();
        t_three_devices();
        t_sixteen_devices();
        t_internal_loop();
        t_internal_fb_high();
      end
      begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule